// File: doc/BRIEF.md
# Sectored Instruction Cache Controller

This block holds the bookkeeping state of an instruction cache of 1K words split into 8 sectors of 128 words. Each sector carries an address tag, one valid bit for every word and a lock bit. A shared recency stack orders the sectors from most to least recently used. The block answers lookups with hit or miss and the sector involved. On a full miss it claims a victim sector. It sets valid bits when words are written, and it carries out flush, lock and unlock-all commands. The data array, the external fetch path and instruction decode sit outside the block.

An input selects one of two modes. In cache mode the tags and the recency stack follow the lookup traffic. In program-RAM mode the low 1K addresses map straight onto the sectors. Tags and recency order stay frozen in that mode, but writes still mark words valid. Leaving cache mode does not flush anything. A word written in program-RAM mode therefore becomes valid under whatever tag its sector still holds.

Top module: `icache_sector_ctrl`

## Requirements
- R1: After reset, sector i holds tag i, all valid bits and lock bits are clear, and the recency stack runs from sector 7 (most recent) down to sector 0 (least recent). No response is pending.
- R2: A flush, in either mode, restores the state of R1: every valid bit is cleared, tags are 0..7, and the victim order becomes 0, 1, 2, and so on.
- R3: A flush clears every lock bit.
- R4: The tag is address bits above 6 and the word offset is bits 6:0. A cache-mode read whose tag matches a sector holding that word as valid returns resp_hit=1 and that sector on resp_sector one cycle later. It also makes that sector the most recent.
- R5: A cache-mode read whose tag matches a sector whose word is not valid returns resp_hit=0 with that sector. It makes the sector the most recent and leaves tags and valid bits alone.
- R6: A cache-mode read with no tag match picks the least recent unlocked sector. That sector takes the new tag, gets all its valid bits cleared and becomes the most recent. The response gives resp_hit=0 and the victim index.
- R7: If a full miss finds every sector locked, the response carries resp_noalloc=1, resp_hit=0 and resp_sector=0, and no state changes.
- R8: A cache-mode write sets the word's valid bit in the sector whose tag matches. With no match it has no effect, and it never changes the recency order. A write produces no response.
- R9: A program-RAM-mode read returns resp_hit=1 with resp_sector = address bits 9:7, whatever the valid bits hold. It changes neither tags nor recency order.
- R10: A program-RAM-mode write to an address below 1024 sets the valid bit of word bits 6:0 in sector bits 9:7, regardless of that sector's tag. Writes at 1024 and above are ignored.
- R11: cmd_lock sets the lock bit of sector cmd_sector and keeps its tag, valid bits and recency position. Locked sectors are never chosen as victims.
- R12: cmd_unlock_all clears every lock bit and leaves tags, valid bits and recency order unchanged.
- R13: Only one action is taken per cycle, in the priority flush, unlock-all, lock, request. A request that loses to a command is dropped and gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_mode | input | 1 | 1 = program-RAM mode, 0 = cache mode |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write (valid-bit set), 0 = read lookup |
| req_addr | input | ADDR_W (16) | Word address of the request |
| cmd_flush | input | 1 | Flush command |
| cmd_lock | input | 1 | Lock the sector named by cmd_sector |
| cmd_unlock_all | input | 1 | Clear all lock bits |
| cmd_sector | input | SEC_W (3) | Sector index for cmd_lock |
| resp_valid | output | 1 | Read response present (one cycle after the read) |
| resp_hit | output | 1 | Read hit |
| resp_sector | output | SEC_W (3) | Hit, matched or victim sector |
| resp_noalloc | output | 1 | Full miss with every sector locked |

## Verification
The lookup path is driven with four patterns, each aimed at one failure:
- Repeated reads of a written word separate a true hit from a hit on a tag alone.
- Reads of unwritten words in a matched sector separate a partial miss from a reallocation.
- Streams of fresh tags show the victim order, and so the effect of recency promotion, locking and flush.
- A mode round trip writes in program-RAM mode under a left-over tag and then reads that tag back in cache mode. This separates mapping by address bits from mapping by tag, and shows that writes at 1K and above are dropped.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [2:0] {
    OP_IDLE, OP_FLUSH, OP_UNLOCK, OP_LOCK, OP_READ, OP_WRITE
  } op_e;

  // One action per cycle: flush > unlock-all > lock > request
  function automatic op_e op_select(input logic flush, input logic unlock,
                                    input logic lock, input logic req,
                                    input logic wr);
    if (flush)       return OP_FLUSH;
    else if (unlock) return OP_UNLOCK;
    else if (lock)   return OP_LOCK;
    else if (req)    return wr ? OP_WRITE : OP_READ;
    else             return OP_IDLE;
  endfunction

endpackage

// File: rtl/icache_sector_store.sv
module icache_sector_store #(
  parameter int NUM_SECTORS = 8,
  parameter int WORDS       = 128,
  parameter int TAG_W       = 9,
  localparam int SEC_W      = $clog2(NUM_SECTORS),
  localparam int OFF_W      = $clog2(WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         unlock_all,
  input  logic                         lock_en,
  input  logic [SEC_W-1:0]             lock_idx,
  input  logic                         tag_ld_en,
  input  logic [SEC_W-1:0]             tag_ld_idx,
  input  logic [TAG_W-1:0]             tag_ld_val,
  input  logic                         vset_en,
  input  logic [SEC_W-1:0]             vset_idx,
  input  logic [OFF_W-1:0]             vset_word,
  output logic [NUM_SECTORS*TAG_W-1:0] tag_flat,
  output logic [NUM_SECTORS*WORDS-1:0] valid_flat,
  output logic [NUM_SECTORS-1:0]       lock_vec
);

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sec
    logic [TAG_W-1:0] tag_q;
    logic [WORDS-1:0] vld_q;
    logic             lck_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q <= TAG_W'(s);
        vld_q <= '0;
        lck_q <= 1'b0;
      end else if (flush) begin
        tag_q <= TAG_W'(s);
        vld_q <= '0;
        lck_q <= 1'b0;
      end else begin
        if (tag_ld_en && tag_ld_idx == SEC_W'(s)) begin
          tag_q <= tag_ld_val;
          vld_q <= '0;
        end else if (vset_en && vset_idx == SEC_W'(s)) begin
          vld_q[vset_word] <= 1'b1;
        end
        if (unlock_all)
          lck_q <= 1'b0;
        else if (lock_en && lock_idx == SEC_W'(s))
          lck_q <= 1'b1;
      end
    end

    assign tag_flat[s*TAG_W +: TAG_W]   = tag_q;
    assign valid_flat[s*WORDS +: WORDS] = vld_q;
    assign lock_vec[s]                  = lck_q;
  end

endmodule

// File: rtl/icache_match.sv
module icache_match #(
  parameter int NUM_SECTORS = 8,
  parameter int WORDS       = 128,
  parameter int TAG_W       = 9,
  localparam int SEC_W      = $clog2(NUM_SECTORS),
  localparam int OFF_W      = $clog2(WORDS)
) (
  input  logic [NUM_SECTORS*TAG_W-1:0] tag_flat,
  input  logic [NUM_SECTORS*WORDS-1:0] valid_flat,
  input  logic [TAG_W-1:0]             lk_tag,
  input  logic [OFF_W-1:0]             lk_word,
  output logic [NUM_SECTORS-1:0]       match_vec,
  output logic                         match_any,
  output logic [SEC_W-1:0]             match_idx,
  output logic                         word_valid
);

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_cmp
    assign match_vec[s] = (tag_flat[s*TAG_W +: TAG_W] == lk_tag);
  end

  assign match_any = |match_vec;

  always_comb begin
    match_idx  = '0;
    word_valid = 1'b0;
    for (int s = 0; s < NUM_SECTORS; s++) begin
      if (match_vec[s]) begin
        match_idx  = SEC_W'(s);
        word_valid = valid_flat[s*WORDS + int'(lk_word)];
      end
    end
  end

endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
  parameter int NUM_SECTORS = 8,
  localparam int SEC_W      = $clog2(NUM_SECTORS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         touch_en,
  input  logic [SEC_W-1:0]             touch_idx,
  input  logic [NUM_SECTORS-1:0]       lock_vec,
  output logic [SEC_W-1:0]             victim_idx,
  output logic                         victim_ok,
  output logic [NUM_SECTORS*SEC_W-1:0] lru_flat
);

  // position 0 = most recent, position NUM_SECTORS-1 = least recent
  logic [SEC_W-1:0] ord_q [NUM_SECTORS];
  logic [SEC_W-1:0] ord_d [NUM_SECTORS];

  function automatic logic [SEC_W-1:0] default_entry(input int pos);
    return SEC_W'(NUM_SECTORS - 1 - pos);
  endfunction

  always_comb begin
    int pos;
    pos = NUM_SECTORS - 1;
    for (int k = 0; k < NUM_SECTORS; k++)
      if (ord_q[k] == touch_idx) pos = k;
    for (int k = 0; k < NUM_SECTORS; k++)
      ord_d[k] = ord_q[k];
    if (touch_en) begin
      ord_d[0] = touch_idx;
      for (int k = 1; k < NUM_SECTORS; k++)
        if (k <= pos) ord_d[k] = ord_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SECTORS; k++) ord_q[k] <= default_entry(k);
    end else if (flush) begin
      for (int k = 0; k < NUM_SECTORS; k++) ord_q[k] <= default_entry(k);
    end else begin
      for (int k = 0; k < NUM_SECTORS; k++) ord_q[k] <= ord_d[k];
    end
  end

  // deepest unlocked entry wins
  always_comb begin
    victim_ok  = 1'b0;
    victim_idx = ord_q[NUM_SECTORS-1];
    for (int k = 0; k < NUM_SECTORS; k++) begin
      if (!lock_vec[ord_q[k]]) begin
        victim_idx = ord_q[k];
        victim_ok  = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NUM_SECTORS; k++) begin : g_flat
    assign lru_flat[k*SEC_W +: SEC_W] = ord_q[k];
  end

endmodule

// File: rtl/icache_sector_ctrl.sv
module icache_sector_ctrl #(
  parameter int NUM_SECTORS = 8,
  parameter int WORDS       = 128,
  parameter int ADDR_W      = 16,
  localparam int SEC_W      = $clog2(NUM_SECTORS),
  localparam int OFF_W      = $clog2(WORDS),
  localparam int TAG_W      = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cmd_flush,
  input  logic              cmd_lock,
  input  logic              cmd_unlock_all,
  input  logic [SEC_W-1:0]  cmd_sector,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [SEC_W-1:0]  resp_sector,
  output logic              resp_noalloc
);
  import icache_pkg::*;

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return TAG_W'(a >> OFF_W);
  endfunction
  function automatic logic [OFF_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return OFF_W'(a);
  endfunction
  function automatic logic [SEC_W-1:0] ram_sector_of(input logic [ADDR_W-1:0] a);
    return SEC_W'(a >> OFF_W);
  endfunction
  function automatic logic in_ram_window(input logic [ADDR_W-1:0] a);
    return (a >> (OFF_W + SEC_W)) == '0;
  endfunction

  op_e                         op;
  logic [TAG_W-1:0]            lk_tag;
  logic [OFF_W-1:0]            lk_word;
  logic [NUM_SECTORS*TAG_W-1:0] tag_flat;
  logic [NUM_SECTORS*WORDS-1:0] valid_flat;
  logic [NUM_SECTORS-1:0]      lock_vec;
  logic [NUM_SECTORS-1:0]      match_vec;
  logic                        match_any, word_valid;
  logic [SEC_W-1:0]            match_idx;
  logic [SEC_W-1:0]            victim_idx;
  logic                        victim_ok;
  logic [NUM_SECTORS*SEC_W-1:0] lru_flat;

  logic                        touch_en, tag_ld_en, vset_en;
  logic [SEC_W-1:0]            touch_idx, vset_idx;
  logic                        ev_hit, ev_partial, ev_alloc, ev_noalloc;
  logic                        rsp_hit_d;
  logic [SEC_W-1:0]            rsp_sec_d;

  assign op      = op_select(cmd_flush, cmd_unlock_all, cmd_lock, req_valid, req_write);
  assign lk_tag  = tag_of(req_addr);
  assign lk_word = word_of(req_addr);

  always_comb begin
    touch_en   = 1'b0;
    touch_idx  = match_idx;
    tag_ld_en  = 1'b0;
    vset_en    = 1'b0;
    vset_idx   = match_idx;
    ev_hit     = 1'b0;
    ev_partial = 1'b0;
    ev_alloc   = 1'b0;
    ev_noalloc = 1'b0;
    rsp_hit_d  = 1'b0;
    rsp_sec_d  = '0;
    case (op)
      OP_READ: begin
        if (ram_mode) begin
          rsp_hit_d = 1'b1;
          rsp_sec_d = ram_sector_of(req_addr);
        end else if (match_any && word_valid) begin
          ev_hit    = 1'b1;
          touch_en  = 1'b1;
          rsp_hit_d = 1'b1;
          rsp_sec_d = match_idx;
        end else if (match_any) begin
          ev_partial = 1'b1;
          touch_en   = 1'b1;
          rsp_sec_d  = match_idx;
        end else if (victim_ok) begin
          ev_alloc  = 1'b1;
          tag_ld_en = 1'b1;
          touch_en  = 1'b1;
          touch_idx = victim_idx;
          rsp_sec_d = victim_idx;
        end else begin
          ev_noalloc = 1'b1;
        end
      end
      OP_WRITE: begin
        if (ram_mode) begin
          vset_en  = in_ram_window(req_addr);
          vset_idx = ram_sector_of(req_addr);
        end else begin
          vset_en  = match_any;
        end
      end
      default: ;
    endcase
  end

  icache_sector_store #(.NUM_SECTORS(NUM_SECTORS), .WORDS(WORDS), .TAG_W(TAG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (op == OP_FLUSH),
    .unlock_all (op == OP_UNLOCK),
    .lock_en    (op == OP_LOCK),
    .lock_idx   (cmd_sector),
    .tag_ld_en  (tag_ld_en),
    .tag_ld_idx (victim_idx),
    .tag_ld_val (lk_tag),
    .vset_en    (vset_en),
    .vset_idx   (vset_idx),
    .vset_word  (lk_word),
    .tag_flat   (tag_flat),
    .valid_flat (valid_flat),
    .lock_vec   (lock_vec)
  );

  icache_match #(.NUM_SECTORS(NUM_SECTORS), .WORDS(WORDS), .TAG_W(TAG_W)) u_match (
    .tag_flat   (tag_flat),
    .valid_flat (valid_flat),
    .lk_tag     (lk_tag),
    .lk_word    (lk_word),
    .match_vec  (match_vec),
    .match_any  (match_any),
    .match_idx  (match_idx),
    .word_valid (word_valid)
  );

  icache_lru #(.NUM_SECTORS(NUM_SECTORS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (op == OP_FLUSH),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .lock_vec   (lock_vec),
    .victim_idx (victim_idx),
    .victim_ok  (victim_ok),
    .lru_flat   (lru_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_hit     <= 1'b0;
      resp_sector  <= '0;
      resp_noalloc <= 1'b0;
    end else begin
      resp_valid   <= (op == OP_READ);
      resp_hit     <= rsp_hit_d;
      resp_sector  <= rsp_sec_d;
      resp_noalloc <= ev_noalloc;
    end
  end

endmodule

// File: rtl/icache_sector_ctrl_chk.sv
module icache_sector_ctrl_chk #(
  parameter int NUM_SECTORS = 8,
  parameter int WORDS       = 128,
  parameter int TAG_W       = 9,
  localparam int SEC_W      = $clog2(NUM_SECTORS)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         ram_mode,
  input logic                         req_valid,
  input logic                         req_write,
  input logic                         cmd_flush,
  input logic                         cmd_lock,
  input logic                         cmd_unlock_all,
  input logic                         resp_valid,
  input logic                         resp_hit,
  input logic                         resp_noalloc,
  input logic [NUM_SECTORS*TAG_W-1:0] tag_flat,
  input logic [NUM_SECTORS*WORDS-1:0] valid_flat,
  input logic [NUM_SECTORS*SEC_W-1:0] lru_flat,
  input logic [NUM_SECTORS-1:0]       lock_vec,
  input logic [NUM_SECTORS-1:0]       match_vec,
  input logic                         ev_alloc,
  input logic                         ev_noalloc,
  input logic [SEC_W-1:0]             victim_idx
);

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush |=> (valid_flat == '0) && (lock_vec == '0)); // R3

  AST_RAM_TAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ram_mode && !cmd_flush |=> $stable(tag_flat)); // R9

  AST_RAM_LRU_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ram_mode && !cmd_flush |=> $stable(lru_flat)); // R9

  AST_NOALLOC_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_noalloc |-> (&lock_vec)); // R7

  AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |-> !lock_vec[victim_idx]); // R6

  AST_TAGS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R6

  AST_LOCK_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lock && !cmd_flush && !cmd_unlock_all |=>
      $stable(tag_flat) && $stable(valid_flat) && $stable(lru_flat)); // R11

  AST_UNLOCK_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unlock_all && !cmd_flush |=>
      (lock_vec == '0) && $stable(tag_flat) && $stable(valid_flat) && $stable(lru_flat)); // R12

  AST_RESP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && !req_write && !cmd_flush && !cmd_unlock_all && !cmd_lock)); // R13

  AST_HIT_NOT_NOALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_hit && resp_noalloc)); // R7

endmodule

bind icache_sector_ctrl icache_sector_ctrl_chk #(
  .NUM_SECTORS(NUM_SECTORS), .WORDS(WORDS), .TAG_W(TAG_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ram_mode       (ram_mode),
  .req_valid      (req_valid),
  .req_write      (req_write),
  .cmd_flush      (cmd_flush),
  .cmd_lock       (cmd_lock),
  .cmd_unlock_all (cmd_unlock_all),
  .resp_valid     (resp_valid),
  .resp_hit       (resp_hit),
  .resp_noalloc   (resp_noalloc),
  .tag_flat       (tag_flat),
  .valid_flat     (valid_flat),
  .lru_flat       (lru_flat),
  .lock_vec       (lock_vec),
  .match_vec      (match_vec),
  .ev_alloc       (ev_alloc),
  .ev_noalloc     (ev_noalloc),
  .victim_idx     (victim_idx)
);

// File: tb/tb_icache_sector_ctrl.sv
module tb_icache_sector_ctrl;
  localparam int ADDR_W = 16;
  localparam int SEC_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ram_mode = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic cmd_flush = 1'b0, cmd_lock = 1'b0, cmd_unlock_all = 1'b0;
  logic [SEC_W-1:0] cmd_sector = '0;
  logic resp_valid, resp_hit, resp_noalloc;
  logic [SEC_W-1:0] resp_sector;

  always #2.5 clk = ~clk;

  icache_sector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ram_mode(ram_mode),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .cmd_flush(cmd_flush), .cmd_lock(cmd_lock), .cmd_unlock_all(cmd_unlock_all),
    .cmd_sector(cmd_sector), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_sector(resp_sector), .resp_noalloc(resp_noalloc)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [4:0] exp_q [$];   // {hit, noalloc, sector}
  string      rid_q [$];

  // monitor: compares every response against the scoreboard
  always begin
    @(posedge clk);
    #2;
    if (rst_n && resp_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R13: unexpected response hit=%0b na=%0b sec=%0d, expected none",
                 resp_hit, resp_noalloc, resp_sector);
      end else begin
        logic [4:0] e;
        string r;
        e = exp_q.pop_front();
        r = rid_q.pop_front();
        if ({resp_hit, resp_noalloc, resp_sector} !== e) begin
          n_fail++;
          $display("FAIL %s: got hit=%0b na=%0b sec=%0d, expected hit=%0b na=%0b sec=%0d",
                   r, resp_hit, resp_noalloc, resp_sector, e[4], e[3], e[2:0]);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    req_valid = 0; req_write = 0; cmd_flush = 0; cmd_lock = 0; cmd_unlock_all = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic h, input logic [2:0] s,
                    input logic na, input string r);
    exp_q.push_back({h, na, s});
    rid_q.push_back(r);
    req_valid = 1; req_write = 0; req_addr = a;
    step();
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a);
    req_valid = 1; req_write = 1; req_addr = a;
    step();
  endtask

  task automatic lock(input logic [2:0] s);
    cmd_lock = 1; cmd_sector = s;
    step();
  endtask

  task automatic flush();
    cmd_flush = 1;
    step();
  endtask

  task automatic unlock_all();
    cmd_unlock_all = 1;
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;
    n_checks++;
    if (resp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: resp_valid=%0b after reset, expected 0", resp_valid);
    end
    #1;

    // identity tags after reset, nothing valid
    rd(16'd0, 0, 3'd0, 0, "R1");            // order 0,7,6,5,4,3,2,1
    wr(16'd0);
    rd(16'd0, 1, 3'd0, 0, "R4 R8");
    rd(16'h1000, 0, 3'd1, 0, "R6");          // order 1,0,7,6,5,4,3,2
    rd(16'h1000, 0, 3'd1, 0, "R5");
    wr(16'h1005);
    rd(16'h1005, 1, 3'd1, 0, "R8");
    wr(16'h2001);                            // no tag match: no effect
    rd(16'h2001, 0, 3'd2, 0, "R8 R6");       // order 2,1,0,7,6,5,4,3
    rd(16'd0, 1, 3'd0, 0, "R4");             // order 0,2,1,7,6,5,4,3
    rd(16'h3000, 0, 3'd3, 0, "R4 R6");       // order 3,0,2,1,7,6,5,4

    lock(3'd4); lock(3'd5); lock(3'd6);
    rd(16'h4000, 0, 3'd7, 0, "R11");         // order 7,3,0,2,1,6,5,4
    rd(16'd512, 0, 3'd4, 0, "R11");          // locked keeps tag 4
    lock(3'd0); lock(3'd1); lock(3'd2); lock(3'd3); lock(3'd7);
    rd(16'h5000, 0, 3'd0, 1, "R7");
    rd(16'd0, 1, 3'd0, 0, "R7");             // order 0,4,7,3,2,1,6,5
    unlock_all();
    rd(16'h5000, 0, 3'd5, 0, "R12");
    rd(16'd0, 1, 3'd0, 0, "R12");

    // lock everything, flush with a colliding read (dropped)
    for (int i = 0; i < 8; i++) lock(3'(i));
    req_valid = 1; req_write = 0; req_addr = 16'd0; cmd_flush = 1;
    step();
    rd(16'd0, 0, 3'd0, 0, "R2 R13");         // order 0,7,6,5,4,3,2,1
    rd(16'd384, 0, 3'd3, 0, "R2");           // order 3,0,7,6,5,4,2,1
    rd(16'd25600, 0, 3'd1, 0, "R2 R3");      // tag 200 -> sector 1
    rd(16'd25728, 0, 3'd2, 0, "R2 R3");      // tag 201 -> sector 2

    // program-RAM mode
    ram_mode = 1'b1;
    rd(16'h7777, 1, 3'd6, 0, "R9");
    wr(16'd130);                             // sector 1 word 2 under tag 200
    wr(16'd1280);                            // beyond 1K: ignored
    ram_mode = 1'b0;
    rd(16'd25602, 1, 3'd1, 0, "R10");        // order 1,2,3,0,7,6,5,4
    rd(16'd25728, 0, 3'd2, 0, "R10");        // order 2,1,3,0,7,6,5,4
    rd(16'd1280, 0, 3'd4, 0, "R9");          // LRU untouched in RAM mode

    ram_mode = 1'b1;
    flush();
    ram_mode = 1'b0;
    rd(16'd25602, 0, 3'd0, 0, "R2");

    repeat (3) @(posedge clk);
    #3;
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R13: %0d responses missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R13: watchdog expired, got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule